// File: doc/BRIEF.md
# Parallel Protocol Request Message Checker

The block takes an eight-byte extended negotiation message one byte at a time and decides whether to adopt the transfer agreement it carries. Bytes arrive with a valid/ready handshake. A start flag marks the first byte of each message. The block checks the three leading header bytes and collects the transfer period factor, the REQ/ACK offset, the bus width exponent and the protocol option byte. It then tests these fields against the combination rules.

An accepted message replaces the stored negotiated settings. A rejected message leaves them as they were. An asynchronous-mode flag is derived from the stored offset. When an accepted message changes the information-unit option, the block raises a one-cycle request to abort every task of the initiator and release the bus. The bus phase controller sits next to the block and acts on the verdict and abort pulses.

Top module: `ppr_checker`

## Requirements
- R1: A message is rejected when byte 0 is not 01h, byte 1 is not 06h or byte 2 is not 04h. The verdict comes once all eight bytes have been taken.
- R2: In an accepted message, byte 3 is the period factor, byte 5 the offset, byte 6 the width exponent and byte 7 the option byte. The option byte runs from bit 7 down to bit 0 as: precompensation enable, retain training, read streaming, write flow control, hold margin settings, quick arbitration request, DT request, IU request. Byte 4 is ignored. The four fields appear on the setting outputs in the same cycle as accept_o. accept_o and reject_o are never high together.
- R3: With a period factor of 08h, a message is rejected unless option bit 1 (DT) and option bit 0 (IU) are both 1. The other six option bits are free.
- R4: A message with option bit 1 (DT) set and a width exponent of 0 is rejected.
- R5: async_o is high exactly when the stored offset is 0.
- R6: A byte with the start flag that arrives before the eighth byte of the current message rejects the partial message. That byte then starts a new message.
- R7: A rejected message leaves every stored setting unchanged.
- R8: abort_o is a one-cycle pulse. It comes together with accept_o, and only when the accepted option bit 0 (IU) differs from the stored value.
- R9: After reset the settings read period 0, offset 0, width 0 and options 0. async_o is 1, in_ready_o is 1 and every pulse output is 0.
- R10: in_ready_o is low for one cycle, the cycle right after the eighth byte is taken. The verdict pulse appears one cycle after that.
- R11: A byte without the start flag is dropped when no message is open, and it produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte valid |
| in_sop_i | input | 1 | First byte of a message |
| in_data_i | input | 8 | Message byte |
| in_ready_o | output | 1 | Byte can be taken |
| accept_o | output | 1 | Message accepted (pulse) |
| reject_o | output | 1 | Message rejected (pulse) |
| period_o | output | 8 | Stored transfer period factor |
| offset_o | output | 8 | Stored REQ/ACK offset |
| width_o | output | 8 | Stored width exponent |
| opts_o | output | 8 | Stored option byte |
| async_o | output | 1 | Stored offset is zero |
| abort_o | output | 1 | Abort all tasks and release the bus (pulse) |

## Verification
The bench targets messages with a period of 08h where only DT or only IU is set. A design that checks only one of the two bits would accept these. It sends DT requests on a narrow bus, which a design that ignores width would adopt. It cuts a message short with a new start byte. A design that does not reject the fragment would either stay silent or lose the message that follows. It also sends IU toggles and repeats, which catch an abort that fires on every accept or on none. Stray bytes before any start flag and a nonzero reserved byte check that neither affects the verdict.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int MSG_BYTES  = 8;
  localparam int HDR_BYTES  = 3;
  localparam int IDX_PERIOD = 3;
  localparam int IDX_OFFSET = 5;
  localparam int IDX_WIDTH  = 6;
  localparam int IDX_OPTS   = 7;

  localparam logic [7:0] HDR_EXT  = 8'h01;
  localparam logic [7:0] HDR_LEN  = 8'h06;
  localparam logic [7:0] HDR_CODE = 8'h04;

  // option byte bit positions
  localparam int OPT_IU     = 0;
  localparam int OPT_DT     = 1;
  localparam int OPT_QAS    = 2;
  localparam int OPT_HOLD   = 3;
  localparam int OPT_WRFLOW = 4;
  localparam int OPT_RDSTRM = 5;
  localparam int OPT_RTI    = 6;
  localparam int OPT_PCOMP  = 7;

  typedef struct packed {
    logic [7:0] period;
    logic [7:0] offset;
    logic [7:0] width;
    logic [7:0] opts;
  } ppr_set_t;

  localparam ppr_set_t SET_RESET = '{period: 8'h00, offset: 8'h00, width: 8'h00, opts: 8'h00};

  function automatic logic [7:0] hdr_byte(input int pos);
    case (pos)
      0:       return HDR_EXT;
      1:       return HDR_LEN;
      default: return HDR_CODE;
    endcase
  endfunction
endpackage

// File: rtl/ppr_frame_rx.sv
module ppr_frame_rx
  import ppr_pkg::*;
#(
  parameter int N_BYTES = MSG_BYTES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sop_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       full_o,
  output logic       trunc_o,
  output logic       hdr_ok_o,
  output ppr_set_t   fields_o
);
  localparam int IDX_W = $clog2(N_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic             active_q, hdr_bad_q, full_q, trunc_q;
  ppr_set_t         cap_q;
  logic             take;

  assign ready_o  = !full_q;
  assign take     = valid_i && ready_o;
  assign full_o   = full_q;
  assign trunc_o  = trunc_q;
  assign hdr_ok_o = !hdr_bad_q;
  assign fields_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      active_q  <= 1'b0;
      hdr_bad_q <= 1'b0;
      full_q    <= 1'b0;
      trunc_q   <= 1'b0;
      cap_q     <= SET_RESET;
    end else begin
      full_q  <= 1'b0;
      trunc_q <= 1'b0;
      if (take) begin
        if (sop_i) begin
          trunc_q   <= active_q;  // an open message is cut short
          active_q  <= 1'b1;
          idx_q     <= IDX_W'(1);
          hdr_bad_q <= (data_i != HDR_EXT);
        end else if (active_q) begin
          if (idx_q < IDX_W'(HDR_BYTES))
            hdr_bad_q <= hdr_bad_q | (data_i != hdr_byte(int'(idx_q)));
          if (idx_q == IDX_W'(IDX_PERIOD)) cap_q.period <= data_i;
          if (idx_q == IDX_W'(IDX_OFFSET)) cap_q.offset <= data_i;
          if (idx_q == IDX_W'(IDX_WIDTH))  cap_q.width  <= data_i;
          if (idx_q == IDX_W'(IDX_OPTS))   cap_q.opts   <= data_i;
          if (idx_q == LAST_IDX) begin
            active_q <= 1'b0;
            full_q   <= 1'b1;
            idx_q    <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
      end
    end
  end

  // R10
  ready_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);

  // R6
  frame_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && trunc_o));

  // R11
  no_idle_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !(valid_i && sop_i)) |=> !full_o && !trunc_o);
endmodule

// File: rtl/ppr_rule_chk.sv
module ppr_rule_chk
  import ppr_pkg::*;
#(
  parameter logic [7:0] FAST_PERIOD = 8'h08
) (
  input  logic [7:0] period_i,
  input  logic [7:0] width_i,
  input  logic [7:0] opts_i,
  output logic       rule_ok_o
);
  logic fast_bad, narrow_dt_bad;

  always_comb begin
    fast_bad      = (period_i == FAST_PERIOD) && !(opts_i[OPT_DT] && opts_i[OPT_IU]);
    narrow_dt_bad = opts_i[OPT_DT] && (width_i == 8'h00);
    rule_ok_o     = !fast_bad && !narrow_dt_bad;
  end
endmodule

// File: rtl/ppr_setting_reg.sv
module ppr_setting_reg
  import ppr_pkg::*;
#(
  parameter logic [7:0] FAST_PERIOD = 8'h08
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     full_i,
  input  logic     trunc_i,
  input  logic     hdr_ok_i,
  input  logic     rule_ok_i,
  input  ppr_set_t cand_i,
  output ppr_set_t set_o,
  output logic     accept_o,
  output logic     reject_o,
  output logic     abort_o
);
  ppr_set_t set_q;
  logic     good;

  assign good  = full_i && hdr_ok_i && rule_ok_i;
  assign set_o = set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q    <= SET_RESET;
      accept_o <= 1'b0;
      reject_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      accept_o <= good;
      reject_o <= trunc_i || (full_i && !good);
      abort_o  <= good && (cand_i.opts[OPT_IU] != set_q.opts[OPT_IU]);
      if (good) set_q <= cand_i;
    end
  end

  // R2
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));

  // R7
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $stable(set_q));

  // R8
  abort_with_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> accept_o);

  // R8
  abort_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (set_q.opts[OPT_IU] != $past(set_q.opts[OPT_IU])));

  // R3
  fast_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && set_q.period == FAST_PERIOD) |-> (set_q.opts[OPT_DT] && set_q.opts[OPT_IU]));

  // R4
  narrow_dt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !(set_q.opts[OPT_DT] && set_q.width == 8'h00));
endmodule

// File: rtl/ppr_checker.sv
module ppr_checker
  import ppr_pkg::*;
#(
  parameter logic [7:0] FAST_PERIOD = 8'h08
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       accept_o,
  output logic       reject_o,
  output logic [7:0] period_o,
  output logic [7:0] offset_o,
  output logic [7:0] width_o,
  output logic [7:0] opts_o,
  output logic       async_o,
  output logic       abort_o
);
  logic     full, trunc, hdr_ok, rule_ok;
  ppr_set_t cand, set;

  ppr_frame_rx #(.N_BYTES(MSG_BYTES)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .sop_i    (in_sop_i),
    .data_i   (in_data_i),
    .ready_o  (in_ready_o),
    .full_o   (full),
    .trunc_o  (trunc),
    .hdr_ok_o (hdr_ok),
    .fields_o (cand)
  );

  ppr_rule_chk #(.FAST_PERIOD(FAST_PERIOD)) u_rule (
    .period_i  (cand.period),
    .width_i   (cand.width),
    .opts_i    (cand.opts),
    .rule_ok_o (rule_ok)
  );

  ppr_setting_reg #(.FAST_PERIOD(FAST_PERIOD)) u_set (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .full_i    (full),
    .trunc_i   (trunc),
    .hdr_ok_i  (hdr_ok),
    .rule_ok_i (rule_ok),
    .cand_i    (cand),
    .set_o     (set),
    .accept_o  (accept_o),
    .reject_o  (reject_o),
    .abort_o   (abort_o)
  );

  assign period_o = set.period;
  assign offset_o = set.offset;
  assign width_o  = set.width;
  assign opts_o   = set.opts;
  assign async_o  = (set.offset == 8'h00);

  // R5
  async_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (async_o == (offset_o == 8'h00)));
endmodule

// File: tb/ppr_checker_bench.sv
`timescale 1ns/1ps
module ppr_checker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, accept, reject, async_m, abort_p;
  logic [7:0] period, offset, width, opts;

  int checks = 0, failures = 0;
  int acc_cnt = 0, rej_cnt = 0;
  bit done = 1'b0;
  logic [7:0] msg [8];
  logic [31:0] model = 32'h0;  // {period, offset, width, opts}

  always #2.5 clk = ~clk;

  ppr_checker u_ppr_checker (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sop_i(in_sop),
    .in_data_i(in_data), .in_ready_o(in_ready), .accept_o(accept), .reject_o(reject),
    .period_o(period), .offset_o(offset), .width_o(width), .opts_o(opts),
    .async_o(async_m), .abort_o(abort_p)
  );

  always @(negedge clk) begin
    if (accept) acc_cnt++;
    if (reject) rej_cnt++;
  end

  // {period, offset, width, opts, expect_accept}
  localparam logic [39:0] VEC [10] = '{
    {8'h0A, 8'h0F, 8'h01, 8'h00, 8'h01},
    {8'h08, 8'h3F, 8'h01, 8'h03, 8'h01},
    {8'h08, 8'h3F, 8'h01, 8'h02, 8'h00},
    {8'h08, 8'h3F, 8'h01, 8'h01, 8'h00},
    {8'h0A, 8'h10, 8'h00, 8'h02, 8'h00},
    {8'h09, 8'h00, 8'h00, 8'hF1, 8'h01},
    {8'h0C, 8'h20, 8'h01, 8'hFE, 8'h01},
    {8'h08, 8'h7F, 8'h01, 8'hFF, 8'h01},
    {8'h19, 8'h05, 8'h00, 8'h00, 8'h01},
    {8'h08, 8'h10, 8'h00, 8'h03, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] p, input logic [7:0] o, input logic [7:0] w, input logic [7:0] op);
    msg[0] = 8'h01; msg[1] = 8'h06; msg[2] = 8'h04; msg[3] = p;
    msg[4] = 8'hA5; msg[5] = o; msg[6] = w; msg[7] = op;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_data = msg[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  // full message, checks timing, verdict, abort and stored settings
  task automatic run_msg(input string tag, input bit exp_acc);
    logic exp_ab;
    logic [31:0] newset;
    newset = {msg[3], msg[5], msg[6], msg[7]};
    exp_ab = exp_acc && (msg[7][0] != model[0]);
    send(8);
    chk({tag, " R10 ready low"}, {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    chk({tag, " R10 ready back"}, {31'b0, in_ready}, 32'd1);
    chk({tag, " accept"}, {31'b0, accept}, {31'b0, exp_acc});
    chk({tag, " reject"}, {31'b0, reject}, {31'b0, !exp_acc});
    chk({tag, " R8 abort"}, {31'b0, abort_p}, {31'b0, exp_ab});
    if (exp_acc) model = newset;
    chk({tag, " R2/R7 settings"}, {period, offset, width, opts}, model);
    chk({tag, " R5 async"}, {31'b0, async_m}, {31'b0, model[23:16] == 8'h00});
    @(negedge clk);
    chk({tag, " R8 abort one cycle"}, {31'b0, abort_p}, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk("R9 settings", {period, offset, width, opts}, 32'h0);
    chk("R9 async", {31'b0, async_m}, 32'd1);
    chk("R9 ready", {31'b0, in_ready}, 32'd1);
    chk("R9 pulses", {29'b0, accept, reject, abort_p}, 32'd0);

    // table: R2 R3 R4 R5 R8
    for (int k = 0; k < 10; k++) begin
      fill(VEC[k][39:32], VEC[k][31:24], VEC[k][23:16], VEC[k][15:8]);
      run_msg($sformatf("R3/R4 vec%0d", k), VEC[k][0]);
    end

    // R1 bad header bytes
    fill(8'h0B, 8'h11, 8'h01, 8'h01); msg[0] = 8'h02; run_msg("R1 byte0", 1'b0);
    fill(8'h0B, 8'h11, 8'h01, 8'h01); msg[1] = 8'h07; run_msg("R1 byte1", 1'b0);
    fill(8'h0B, 8'h11, 8'h01, 8'h01); msg[2] = 8'h05; run_msg("R1 byte2", 1'b0);

    // R6 early end: fragment then full message
    a0 = acc_cnt; r0 = rej_cnt;
    fill(8'h0B, 8'h11, 8'h01, 8'h01);
    send(4);
    repeat (3) @(negedge clk);
    chk("R6 no verdict yet", rej_cnt - r0, 32'd0);
    fill(8'h0D, 8'h22, 8'h01, 8'h03);
    run_msg("R6 follow-on", 1'b1);
    repeat (2) @(negedge clk);
    chk("R6 fragment reject", rej_cnt - r0, 32'd1);
    chk("R6 follow accept", acc_cnt - a0, 32'd1);

    // R11 stray bytes with no open message
    a0 = acc_cnt; r0 = rej_cnt;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_data = (i == 0) ? 8'h01 : 8'h08;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 no verdict", (acc_cnt - a0) + (rej_cnt - r0), 32'd0);
    chk("R11 settings kept", {period, offset, width, opts}, model);
    fill(8'h08, 8'h00, 8'h01, 8'h07);
    run_msg("R11 then valid", 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule